// File: doc/BRIEF.md
# Three-ROM Microcoded Control Sequencer

This block is the control unit of a small bus-based 32-bit processor. A 6-bit microstate register addresses a main ROM. Each 25-bit word of that ROM carries a 6-bit successor state and a set of control lines. The control lines enable bus drivers, load datapath registers, write the register file or memory, pick a register-number field, pick an ALU function, and request a dispatch. The datapath itself is outside this block.

The next microstate comes from one of three sources. The first is the successor field of the current word. The second is a sequencer ROM with one entry per instruction opcode. The third is a condition ROM with one entry for a false comparison and one for a true comparison. Two bits of the control word choose the source: the opcode dispatch bit and the compare dispatch bit. Each ROM image is a parameter. The default images hold a complete microprogram: a three-state fetch and a routine for each of ten instructions. A single-step enable freezes the machine when it is low.

Top module: `ucode_sequencer`

## Requirements
- R1: While rst_ni is low, the state register is 0 (the first fetch microstate), and the reset takes effect without waiting for a clock edge.
- R2: The control outputs are the bits of the main ROM word at the current state. Bits 5:0 are the successor field. Bits 6 to 10 are, in order, the drive enables for register, memory, ALU, PC and offset. Bits 11 to 18 are, in order, the loads of PC, IR, MAR, A, B and compare, then the register write and the memory write. Bits 20:19 are reg_sel_o. Bits 22:21 are alu_op_o. Bit 23 is op_test_o and bit 24 is chk_cmp_o.
- R3: When step_en_i is high and bits 23 and 24 are both 0, the next state is bits 5:0 of the word.
- R4: When step_en_i is high and bit 23 is set, the next state is the sequencer ROM entry indexed by opcode_i.
- R5: When step_en_i is high and bit 24 is set, the next state is the condition ROM entry indexed by cmp_i (0 means false, 1 means true). A microprogram must never set bits 23 and 24 together.
- R6: When step_en_i is low, the state does not change.
- R7: In the default microprogram, state 0 asserts ld_mar_o and state 1 asserts ld_ir_o. State 2 asserts ld_pc_o and op_test_o.
- R8: In the default microprogram, opcodes 0 to 6, 8 and 9 return to state 0 within 10 microstates after dispatch. Opcode 8 with cmp_i=1 takes exactly two microstates more than with cmp_i=0.
- R9: In the default microprogram, opcode 7 and opcodes 10 to 15 park in a state that repeats itself. That state asserts none of wr_reg_o, wr_mem_o and ld_pc_o.
- R10: In the default microprogram, opcodes 0, 1, 2, 3, 6 and 9 assert wr_reg_o in exactly one microstate. Opcode 4 asserts wr_mem_o once and never wr_reg_o. Opcodes 5 and 8 write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| step_en_i | input | 1 | Advance enable; state held when low |
| opcode_i | input | 4 | Opcode from the instruction register |
| cmp_i | input | 1 | Latched comparison result |
| state_o | output | 6 | Current microstate |
| drv_reg_o | output | 1 | Register file drives bus |
| drv_mem_o | output | 1 | Memory drives bus |
| drv_alu_o | output | 1 | ALU drives bus |
| drv_pc_o | output | 1 | PC drives bus |
| drv_off_o | output | 1 | Sign-extended offset drives bus |
| ld_pc_o | output | 1 | Load PC |
| ld_ir_o | output | 1 | Load IR |
| ld_mar_o | output | 1 | Load MAR |
| ld_a_o | output | 1 | Load ALU operand A |
| ld_b_o | output | 1 | Load ALU operand B |
| ld_cmp_o | output | 1 | Load comparison flag |
| wr_reg_o | output | 1 | Register file write |
| wr_mem_o | output | 1 | Memory write |
| reg_sel_o | output | 2 | Register-number field select |
| alu_op_o | output | 2 | ALU function |
| op_test_o | output | 1 | Opcode dispatch request |
| chk_cmp_o | output | 1 | Compare dispatch request |

## Verification
A dispatch request and a deasserted step enable can fall in the same cycle. The hold must then win over the sequencer or condition ROM lookup. A test instance gets pseudo-random ROM images with many dispatch words, and step_en_i is driven low about one cycle in four. Every such overlap is therefore hit many times, and each is judged by whether state_o stayed put. A second instance runs the built-in microprogram per opcode. It counts microstates and writes, and compares the compare-true path with the compare-false path.

// File: rtl/ucseq_pkg.sv
package ucseq_pkg;

  localparam int unsigned CTRL_W = 19;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned N_DRV  = 5;
  localparam int unsigned N_LD   = 6;

  // bit offsets above the successor field
  localparam int unsigned O_DR_REG = 0;
  localparam int unsigned O_DR_MEM = 1;
  localparam int unsigned O_DR_ALU = 2;
  localparam int unsigned O_DR_PC  = 3;
  localparam int unsigned O_DR_OFF = 4;
  localparam int unsigned O_LD_PC  = 5;
  localparam int unsigned O_LD_IR  = 6;
  localparam int unsigned O_LD_MAR = 7;
  localparam int unsigned O_LD_A   = 8;
  localparam int unsigned O_LD_B   = 9;
  localparam int unsigned O_LD_CMP = 10;
  localparam int unsigned O_WR_REG = 11;
  localparam int unsigned O_WR_MEM = 12;
  localparam int unsigned O_RSEL   = 13;
  localparam int unsigned O_ALU    = 15;
  localparam int unsigned O_OPT    = 17;
  localparam int unsigned O_CHK    = 18;

  typedef struct packed {
    logic             chk_cmp;
    logic             op_test;
    logic [SEL_W-1:0] alu_op;
    logic [SEL_W-1:0] reg_sel;
    logic             wr_mem;
    logic             wr_reg;
    logic [N_LD-1:0]  ld;
    logic [N_DRV-1:0] drv;
  } ctrl_t;

  typedef enum logic [1:0] {
    SRC_FIELD = 2'b00,
    SRC_SEQ   = 2'b01,
    SRC_COND  = 2'b10,
    SRC_BAD   = 2'b11
  } src_e;

  // default image geometry
  localparam int unsigned DEF_STATE_W = 6;
  localparam int unsigned DEF_OPC_W   = 4;
  localparam int unsigned DEF_CW_W    = DEF_STATE_W + CTRL_W;
  localparam int unsigned DEF_DEPTH   = 2 ** DEF_STATE_W;
  localparam int unsigned DEF_OPS     = 2 ** DEF_OPC_W;

  localparam logic [1:0] RS_X = 2'd0, RS_Y = 2'd1, RS_Z = 2'd2;
  localparam logic [1:0] AL_ADD = 2'd0, AL_SUB = 2'd1, AL_NAND = 2'd2, AL_INC = 2'd3;

  localparam logic [5:0] S_FETCH0 = 6'd0;
  localparam logic [5:0] S_ADD0   = 6'd3;
  localparam logic [5:0] S_NAND0  = 6'd6;
  localparam logic [5:0] S_ADDI0  = 6'd9;
  localparam logic [5:0] S_LW0    = 6'd12;
  localparam logic [5:0] S_SW0    = 6'd16;
  localparam logic [5:0] S_GOTO0  = 6'd20;
  localparam logic [5:0] S_JALR0  = 6'd23;
  localparam logic [5:0] S_HALT   = 6'd25;
  localparam logic [5:0] S_SKP0   = 6'd26;
  localparam logic [5:0] S_SKPT0  = 6'd30;
  localparam logic [5:0] S_LEA0   = 6'd32;

  localparam logic [CTRL_W-1:0] F_DR_REG = CTRL_W'(1) << O_DR_REG;
  localparam logic [CTRL_W-1:0] F_DR_MEM = CTRL_W'(1) << O_DR_MEM;
  localparam logic [CTRL_W-1:0] F_DR_ALU = CTRL_W'(1) << O_DR_ALU;
  localparam logic [CTRL_W-1:0] F_DR_PC  = CTRL_W'(1) << O_DR_PC;
  localparam logic [CTRL_W-1:0] F_DR_OFF = CTRL_W'(1) << O_DR_OFF;
  localparam logic [CTRL_W-1:0] F_LD_PC  = CTRL_W'(1) << O_LD_PC;
  localparam logic [CTRL_W-1:0] F_LD_IR  = CTRL_W'(1) << O_LD_IR;
  localparam logic [CTRL_W-1:0] F_LD_MAR = CTRL_W'(1) << O_LD_MAR;
  localparam logic [CTRL_W-1:0] F_LD_A   = CTRL_W'(1) << O_LD_A;
  localparam logic [CTRL_W-1:0] F_LD_B   = CTRL_W'(1) << O_LD_B;
  localparam logic [CTRL_W-1:0] F_LD_CMP = CTRL_W'(1) << O_LD_CMP;
  localparam logic [CTRL_W-1:0] F_WR_REG = CTRL_W'(1) << O_WR_REG;
  localparam logic [CTRL_W-1:0] F_WR_MEM = CTRL_W'(1) << O_WR_MEM;
  localparam logic [CTRL_W-1:0] F_OPT    = CTRL_W'(1) << O_OPT;
  localparam logic [CTRL_W-1:0] F_CHK    = CTRL_W'(1) << O_CHK;

  function automatic logic [CTRL_W-1:0] f_rsel(logic [1:0] v);
    return CTRL_W'(v) << O_RSEL;
  endfunction

  function automatic logic [CTRL_W-1:0] f_alu(logic [1:0] v);
    return CTRL_W'(v) << O_ALU;
  endfunction

  function automatic logic [DEF_CW_W-1:0] uw(logic [5:0] nxt, logic [CTRL_W-1:0] c);
    return {c, nxt};
  endfunction

  // operand A from RY, operand B from RZ or the offset, then ALU result to dst
  function automatic logic [DEF_DEPTH*DEF_CW_W-1:0] main_image();
    logic [DEF_CW_W-1:0] w [DEF_DEPTH];
    logic [DEF_DEPTH*DEF_CW_W-1:0] img;
    for (int i = 0; i < DEF_DEPTH; i++) w[i] = uw(S_FETCH0, '0);
    w[0]  = uw(6'd1, F_DR_PC | F_LD_MAR | F_LD_A);
    w[1]  = uw(6'd2, F_DR_MEM | F_LD_IR);
    w[2]  = uw(6'd0, f_alu(AL_INC) | F_DR_ALU | F_LD_PC | F_OPT);
    w[S_ADD0]      = uw(S_ADD0 + 6'd1, f_rsel(RS_Y) | F_DR_REG | F_LD_A);
    w[S_ADD0 + 1]  = uw(S_ADD0 + 6'd2, f_rsel(RS_Z) | F_DR_REG | F_LD_B);
    w[S_ADD0 + 2]  = uw(S_FETCH0, f_alu(AL_ADD) | F_DR_ALU | f_rsel(RS_X) | F_WR_REG);
    w[S_NAND0]     = uw(S_NAND0 + 6'd1, f_rsel(RS_Y) | F_DR_REG | F_LD_A);
    w[S_NAND0 + 1] = uw(S_NAND0 + 6'd2, f_rsel(RS_Z) | F_DR_REG | F_LD_B);
    w[S_NAND0 + 2] = uw(S_FETCH0, f_alu(AL_NAND) | F_DR_ALU | f_rsel(RS_X) | F_WR_REG);
    w[S_ADDI0]     = uw(S_ADDI0 + 6'd1, f_rsel(RS_Y) | F_DR_REG | F_LD_A);
    w[S_ADDI0 + 1] = uw(S_ADDI0 + 6'd2, F_DR_OFF | F_LD_B);
    w[S_ADDI0 + 2] = uw(S_FETCH0, f_alu(AL_ADD) | F_DR_ALU | f_rsel(RS_X) | F_WR_REG);
    w[S_LW0]       = uw(S_LW0 + 6'd1, f_rsel(RS_Y) | F_DR_REG | F_LD_A);
    w[S_LW0 + 1]   = uw(S_LW0 + 6'd2, F_DR_OFF | F_LD_B);
    w[S_LW0 + 2]   = uw(S_LW0 + 6'd3, f_alu(AL_ADD) | F_DR_ALU | F_LD_MAR);
    w[S_LW0 + 3]   = uw(S_FETCH0, F_DR_MEM | f_rsel(RS_X) | F_WR_REG);
    w[S_SW0]       = uw(S_SW0 + 6'd1, f_rsel(RS_Y) | F_DR_REG | F_LD_A);
    w[S_SW0 + 1]   = uw(S_SW0 + 6'd2, F_DR_OFF | F_LD_B);
    w[S_SW0 + 2]   = uw(S_SW0 + 6'd3, f_alu(AL_ADD) | F_DR_ALU | F_LD_MAR);
    w[S_SW0 + 3]   = uw(S_FETCH0, f_rsel(RS_X) | F_DR_REG | F_WR_MEM);
    w[S_GOTO0]     = uw(S_GOTO0 + 6'd1, F_DR_PC | F_LD_A);
    w[S_GOTO0 + 1] = uw(S_GOTO0 + 6'd2, F_DR_OFF | F_LD_B);
    w[S_GOTO0 + 2] = uw(S_FETCH0, f_alu(AL_ADD) | F_DR_ALU | F_LD_PC);
    w[S_JALR0]     = uw(S_JALR0 + 6'd1, F_DR_PC | f_rsel(RS_X) | F_WR_REG);
    w[S_JALR0 + 1] = uw(S_FETCH0, f_rsel(RS_Y) | F_DR_REG | F_LD_PC);
    w[S_HALT]      = uw(S_HALT, '0);
    w[S_SKP0]      = uw(S_SKP0 + 6'd1, f_rsel(RS_Y) | F_DR_REG | F_LD_A);
    w[S_SKP0 + 1]  = uw(S_SKP0 + 6'd2, f_rsel(RS_Z) | F_DR_REG | F_LD_B);
    w[S_SKP0 + 2]  = uw(S_SKP0 + 6'd3, f_alu(AL_SUB) | F_DR_ALU | F_LD_CMP);
    w[S_SKP0 + 3]  = uw(S_FETCH0, F_CHK);
    w[S_SKPT0]     = uw(S_SKPT0 + 6'd1, F_DR_PC | F_LD_A);
    w[S_SKPT0 + 1] = uw(S_FETCH0, f_alu(AL_INC) | F_DR_ALU | F_LD_PC);
    w[S_LEA0]      = uw(S_LEA0 + 6'd1, F_DR_PC | F_LD_A);
    w[S_LEA0 + 1]  = uw(S_LEA0 + 6'd2, F_DR_OFF | F_LD_B);
    w[S_LEA0 + 2]  = uw(S_FETCH0, f_alu(AL_ADD) | F_DR_ALU | f_rsel(RS_X) | F_WR_REG);
    for (int i = 0; i < DEF_DEPTH; i++) img[i*DEF_CW_W +: DEF_CW_W] = w[i];
    return img;
  endfunction

  function automatic logic [DEF_OPS*DEF_STATE_W-1:0] seq_image();
    logic [DEF_OPS*DEF_STATE_W-1:0] img;
    for (int op = 0; op < DEF_OPS; op++) begin
      logic [5:0] s;
      case (op)
        0:       s = S_ADD0;
        1:       s = S_NAND0;
        2:       s = S_ADDI0;
        3:       s = S_LW0;
        4:       s = S_SW0;
        5:       s = S_GOTO0;
        6:       s = S_JALR0;
        8:       s = S_SKP0;
        9:       s = S_LEA0;
        default: s = S_HALT;
      endcase
      img[op*DEF_STATE_W +: DEF_STATE_W] = s;
    end
    return img;
  endfunction

  function automatic logic [2*DEF_STATE_W-1:0] cond_image();
    return {S_SKPT0, S_FETCH0};
  endfunction

endpackage

// File: rtl/ucseq_rom.sv
module ucseq_rom #(
  parameter int unsigned ADDR_W = 1,
  parameter int unsigned DATA_W = 1,
  parameter logic [(2**ADDR_W)*DATA_W-1:0] IMAGE = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned DEPTH = 2 ** ADDR_W;

  logic [DATA_W-1:0] rows [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    assign rows[g] = IMAGE[g*DATA_W +: DATA_W];
  end

  assign data_o = rows[addr_i];
endmodule

// File: rtl/ucseq_next_mux.sv
module ucseq_next_mux
  import ucseq_pkg::*;
#(
  parameter int unsigned STATE_W = 6
) (
  input  logic               op_test_i,
  input  logic               chk_cmp_i,
  input  logic [STATE_W-1:0] field_i,
  input  logic [STATE_W-1:0] seq_i,
  input  logic [STATE_W-1:0] cond_i,
  output logic [STATE_W-1:0] next_o
);
  src_e src;

  always_comb begin
    src = src_e'({chk_cmp_i, op_test_i});
    unique case (src)
      SRC_FIELD: next_o = field_i;
      SRC_SEQ:   next_o = seq_i;
      SRC_COND:  next_o = cond_i;
      default:   next_o = '0;  // illegal dual dispatch: restart fetch
    endcase
  end
endmodule

// File: rtl/ucseq_state_reg.sv
module ucseq_state_reg #(
  parameter int unsigned STATE_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [STATE_W-1:0] d_i,
  output logic [STATE_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
  import ucseq_pkg::*;
#(
  parameter int unsigned STATE_W = DEF_STATE_W,
  parameter int unsigned OPC_W   = DEF_OPC_W,
  parameter logic [(2**STATE_W)*(STATE_W+CTRL_W)-1:0] MAIN_ROM = main_image(),
  parameter logic [(2**OPC_W)*STATE_W-1:0]            SEQ_ROM  = seq_image(),
  parameter logic [2*STATE_W-1:0]                     COND_ROM = cond_image()
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_en_i,
  input  logic [OPC_W-1:0]   opcode_i,
  input  logic               cmp_i,
  output logic [STATE_W-1:0] state_o,
  output logic               drv_reg_o,
  output logic               drv_mem_o,
  output logic               drv_alu_o,
  output logic               drv_pc_o,
  output logic               drv_off_o,
  output logic               ld_pc_o,
  output logic               ld_ir_o,
  output logic               ld_mar_o,
  output logic               ld_a_o,
  output logic               ld_b_o,
  output logic               ld_cmp_o,
  output logic               wr_reg_o,
  output logic               wr_mem_o,
  output logic [SEL_W-1:0]   reg_sel_o,
  output logic [SEL_W-1:0]   alu_op_o,
  output logic               op_test_o,
  output logic               chk_cmp_o
);
  localparam int unsigned CW_W = STATE_W + CTRL_W;

  logic [STATE_W-1:0] state_q, state_n;
  logic [CW_W-1:0]    cw;
  logic [STATE_W-1:0] ns_field, seq_word, cond_word;
  ctrl_t              ctrl;

  ucseq_rom #(.ADDR_W(STATE_W), .DATA_W(CW_W), .IMAGE(MAIN_ROM)) u_main (
    .addr_i(state_q), .data_o(cw)
  );

  ucseq_rom #(.ADDR_W(OPC_W), .DATA_W(STATE_W), .IMAGE(SEQ_ROM)) u_seq (
    .addr_i(opcode_i), .data_o(seq_word)
  );

  ucseq_rom #(.ADDR_W(1), .DATA_W(STATE_W), .IMAGE(COND_ROM)) u_cond (
    .addr_i(cmp_i), .data_o(cond_word)
  );

  assign ns_field = cw[STATE_W-1:0];
  assign ctrl     = ctrl_t'(cw[CW_W-1:STATE_W]);

  ucseq_next_mux #(.STATE_W(STATE_W)) u_mux (
    .op_test_i(ctrl.op_test),
    .chk_cmp_i(ctrl.chk_cmp),
    .field_i  (ns_field),
    .seq_i    (seq_word),
    .cond_i   (cond_word),
    .next_o   (state_n)
  );

  ucseq_state_reg #(.STATE_W(STATE_W)) u_state (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (step_en_i),
    .d_i   (state_n),
    .q_o   (state_q)
  );

  assign state_o   = state_q;
  assign drv_reg_o = ctrl.drv[O_DR_REG];
  assign drv_mem_o = ctrl.drv[O_DR_MEM];
  assign drv_alu_o = ctrl.drv[O_DR_ALU];
  assign drv_pc_o  = ctrl.drv[O_DR_PC];
  assign drv_off_o = ctrl.drv[O_DR_OFF];
  assign ld_pc_o   = ctrl.ld[O_LD_PC  - N_DRV];
  assign ld_ir_o   = ctrl.ld[O_LD_IR  - N_DRV];
  assign ld_mar_o  = ctrl.ld[O_LD_MAR - N_DRV];
  assign ld_a_o    = ctrl.ld[O_LD_A   - N_DRV];
  assign ld_b_o    = ctrl.ld[O_LD_B   - N_DRV];
  assign ld_cmp_o  = ctrl.ld[O_LD_CMP - N_DRV];
  assign wr_reg_o  = ctrl.wr_reg;
  assign wr_mem_o  = ctrl.wr_mem;
  assign reg_sel_o = ctrl.reg_sel;
  assign alu_op_o  = ctrl.alu_op;
  assign op_test_o = ctrl.op_test;
  assign chk_cmp_o = ctrl.chk_cmp;
endmodule

// File: rtl/ucseq_checker.sv
module ucseq_checker #(
  parameter int unsigned STATE_W = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               step_en_i,
  input logic [STATE_W-1:0] state_o,
  input logic               op_test_o,
  input logic               chk_cmp_o,
  input logic [STATE_W-1:0] field_next,
  input logic [STATE_W-1:0] seq_next,
  input logic [STATE_W-1:0] cond_next
);
  a_r1_reset_state: assert property (@(posedge clk_i)
    !rst_ni |=> state_o == '0);

  a_r3_field_path: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_en_i && !op_test_o && !chk_cmp_o |=> state_o == $past(field_next));

  a_r4_opcode_path: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_en_i && op_test_o && !chk_cmp_o |=> state_o == $past(seq_next));

  a_r5_cond_path: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_en_i && chk_cmp_o && !op_test_o |=> state_o == $past(cond_next));

  a_r5_no_dual_dispatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(op_test_o && chk_cmp_o));

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_en_i |=> $stable(state_o));
endmodule

bind ucode_sequencer ucseq_checker #(.STATE_W(STATE_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .step_en_i (step_en_i),
  .state_o   (state_o),
  .op_test_o (op_test_o),
  .chk_cmp_o (chk_cmp_o),
  .field_next(ns_field),
  .seq_next  (seq_word),
  .cond_next (cond_word)
);

// File: tb/tb_ucode_sequencer.sv
`timescale 1ns/1ps
module tb_ucode_sequencer;
  localparam int SW = 6;
  localparam int OW = 4;
  localparam int CW = 25;
  localparam int ND = 64;
  localparam int NO = 16;

  function automatic logic [31:0] xs(logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  function automatic logic [ND*CW-1:0] gen_main();
    logic [ND*CW-1:0] img;
    logic [31:0] x;
    x = 32'h1234abcd;
    for (int i = 0; i < ND; i++) begin
      logic [CW-1:0] w;
      x = xs(x);
      w = x[CW-1:0];
      w[23] = (x[31:30] == 2'd1);
      w[24] = (x[31:30] == 2'd2);
      img[i*CW +: CW] = w;
    end
    return img;
  endfunction

  function automatic logic [NO*SW-1:0] gen_seq();
    logic [NO*SW-1:0] img;
    logic [31:0] x;
    x = 32'h0badf00d;
    for (int i = 0; i < NO; i++) begin
      x = xs(x);
      img[i*SW +: SW] = x[SW-1:0];
    end
    return img;
  endfunction

  localparam logic [ND*CW-1:0] TB_MAIN = gen_main();
  localparam logic [NO*SW-1:0] TB_SEQ  = gen_seq();
  localparam logic [2*SW-1:0]  TB_COND = {6'd45, 6'd17};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic step_en = 1'b0;
  logic [OW-1:0] opcode = '0;
  logic cmp = 1'b0;
  always #5 clk = ~clk;

  logic [SW-1:0] state;
  logic dr_reg, dr_mem, dr_alu, dr_pc, dr_off, l_pc, l_ir, l_mar, l_a, l_b, l_cmp, w_reg, w_mem, opt, chk;
  logic [1:0] rsel, alu;

  ucode_sequencer #(.MAIN_ROM(TB_MAIN), .SEQ_ROM(TB_SEQ), .COND_ROM(TB_COND)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .step_en_i(step_en), .opcode_i(opcode), .cmp_i(cmp),
    .state_o(state), .drv_reg_o(dr_reg), .drv_mem_o(dr_mem), .drv_alu_o(dr_alu),
    .drv_pc_o(dr_pc), .drv_off_o(dr_off), .ld_pc_o(l_pc), .ld_ir_o(l_ir), .ld_mar_o(l_mar),
    .ld_a_o(l_a), .ld_b_o(l_b), .ld_cmp_o(l_cmp), .wr_reg_o(w_reg), .wr_mem_o(w_mem),
    .reg_sel_o(rsel), .alu_op_o(alu), .op_test_o(opt), .chk_cmp_o(chk)
  );

  logic [OW-1:0] d_op = '0;
  logic d_cmp = 1'b0;
  logic [SW-1:0] d_state;
  logic d_dr_reg, d_dr_mem, d_dr_alu, d_dr_pc, d_dr_off, d_l_pc, d_l_ir, d_l_mar, d_l_a, d_l_b, d_l_cmp, d_w_reg, d_w_mem, d_opt, d_chk;
  logic [1:0] d_rsel, d_alu;

  ucode_sequencer dflt (
    .clk_i(clk), .rst_ni(rst_ni), .step_en_i(1'b1), .opcode_i(d_op), .cmp_i(d_cmp),
    .state_o(d_state), .drv_reg_o(d_dr_reg), .drv_mem_o(d_dr_mem), .drv_alu_o(d_dr_alu),
    .drv_pc_o(d_dr_pc), .drv_off_o(d_dr_off), .ld_pc_o(d_l_pc), .ld_ir_o(d_l_ir), .ld_mar_o(d_l_mar),
    .ld_a_o(d_l_a), .ld_b_o(d_l_b), .ld_cmp_o(d_l_cmp), .wr_reg_o(d_w_reg), .wr_mem_o(d_w_mem),
    .reg_sel_o(d_rsel), .alu_op_o(d_alu), .op_test_o(d_opt), .chk_cmp_o(d_chk)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] cw_at(logic [SW-1:0] s);
    return TB_MAIN[s*CW +: CW];
  endfunction

  function automatic logic [18:0] ctrl_now();
    return {chk, opt, alu, rsel, w_mem, w_reg, l_cmp, l_b, l_a, l_mar, l_ir, l_pc,
            dr_off, dr_pc, dr_alu, dr_mem, dr_reg};
  endfunction

  // opcode -> {wr_reg count, wr_mem count} per R10
  function automatic logic [1:0] exp_wr(int op);
    case (op)
      0, 1, 2, 3, 6, 9: return 2'b10;
      4:                return 2'b01;
      default:          return 2'b00;
    endcase
  endfunction

  task automatic pulse_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic run_fetch();
    int guard;
    guard = 0;
    while (d_state != '0 && guard < 40) begin
      @(negedge clk);
      guard++;
    end
    check(d_state == '0 && d_l_mar, "R7 fetch0 ld_mar", {d_state, d_l_mar}, {6'd0, 1'b1});
    @(negedge clk);
    check(d_state == 6'd1 && d_l_ir, "R7 fetch1 ld_ir", {d_state, d_l_ir}, {6'd1, 1'b1});
    @(negedge clk);
    check(d_state == 6'd2 && d_opt && d_l_pc, "R7 fetch2 dispatch", {d_state, d_opt, d_l_pc}, {6'd2, 2'b11});
  endtask

  task automatic run_op(input logic [3:0] op, input logic c, output int n, output int nreg, output int nmem);
    d_op = op;
    d_cmp = c;
    run_fetch();
    n = 0; nreg = 0; nmem = 0;
    forever begin
      @(negedge clk);
      if (d_state == '0 || n > 12) break;
      n++;
      nreg += int'(d_w_reg);
      nmem += int'(d_w_mem);
    end
  endtask

  initial begin
    logic [SW-1:0] exp_state;
    string path;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(state == '0, "R1 held reset", state, 0);
    rst_ni = 1'b1;
    exp_state = '0;
    path = "R1";

    for (int k = 0; k < 3000; k++) begin
      logic [CW-1:0] w;
      @(negedge clk);
      check(state == exp_state, path, state, exp_state);
      w = cw_at(exp_state);
      check(ctrl_now() == w[24:6], "R2 control word", ctrl_now(), w[24:6]);
      if (k == 1500) begin
        rst_ni = 1'b0;
        #1;
        check(state == '0, "R1 async reset", state, 0);
        @(negedge clk);
        rst_ni = 1'b1;
        check(state == '0, "R1 after release", state, 0);
        exp_state = '0;
        w = cw_at(exp_state);
      end
      step_en = ($urandom % 4) != 0;
      opcode  = OW'($urandom);
      cmp     = 1'($urandom);
      if (k % 97 == 5) step_en = 1'b0;
      if (!step_en) begin
        path = "R6 hold";
      end else if (w[23]) begin
        path = "R4 opcode dispatch";
        exp_state = TB_SEQ[opcode*SW +: SW];
      end else if (w[24]) begin
        path = "R5 compare dispatch";
        exp_state = TB_COND[cmp*SW +: SW];
      end else begin
        path = "R3 field successor";
        exp_state = w[5:0];
      end
    end
    @(negedge clk);
    check(state == exp_state, path, state, exp_state);

    // default microprogram walks
    begin
      int n, nr, nm, nf, nt;
      for (int op = 0; op < 10; op++) begin
        if (op == 7 || op == 8) continue;
        run_op(4'(op), 1'b0, n, nr, nm);
        check(n >= 1 && n <= 10, "R8 returns to fetch", n, 10);
        check({nr[0], nm[0]} == exp_wr(op) && nr < 2 && nm < 2, "R10 write count",
              {nr[15:0], nm[15:0]}, {15'd0, exp_wr(op)[1], 15'd0, exp_wr(op)[0]});
      end
      run_op(4'd8, 1'b0, nf, nr, nm);
      check(nr == 0 && nm == 0, "R10 compare no write", nr + nm, 0);
      run_op(4'd8, 1'b1, nt, nr, nm);
      check(nf <= 10 && nt <= 10, "R8 compare returns", nt, 10);
      check(nt == nf + 2, "R8 compare true longer", nt, nf + 2);
    end

    for (int h = 0; h < 2; h++) begin
      logic [SW-1:0] hs;
      d_op = (h == 0) ? 4'd7 : 4'd12;
      run_fetch();
      @(negedge clk);
      hs = d_state;
      repeat (5) begin
        @(negedge clk);
        check(d_state == hs && !d_w_reg && !d_w_mem && !d_l_pc, "R9 park",
              {d_state, d_w_reg, d_w_mem, d_l_pc}, {hs, 3'b000});
      end
      d_op = 4'd0;
      pulse_reset();
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule